// File: doc/BRIEF.md
# Framed Serial Word Master with Select-Edge Clock Pulses

This block is a serial master that moves one 32-bit word per frame to a plain shift-register peripheral and gathers the word that comes back. The word travels as four bytes, highest byte first, and each byte leaves highest bit first. Select is active high. The block is meant for a peripheral that has no clock of its own and runs only on the serial clock. To let such a peripheral see the select change, the master adds one bare serial clock pulse just after raising select and one more just after lowering it.

A frame starts with a one-cycle start strobe while the block is idle. The block then raises busy, walks the frame and lowers busy in the same cycle that it pulses done. The received word is valid from that cycle until the next start. Every serial clock phase, low or high, lasts a fixed number of system clocks set by a parameter.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, select, serial clock, MOSI, busy and done are all 0, and the received word reads 0.
- R2: A start strobe seen while idle raises select and busy in the next cycle.
- R3: While select is high the serial clock rises exactly 33 times. The first pulse, which starts with a low phase, carries no data.
- R4: The 32 data bits leave highest bit first: bits 31..24 (byte 3), then byte 2, byte 1 and byte 0. MOSI changes only while the serial clock is low, and the peripheral reads it on the rising edge.
- R5: Every low phase and every high phase of the serial clock lasts HALF_DIV system clocks (HALF_DIV >= 1).
- R6: MISO is sampled at the end of each data high phase. The k-th sampled bit (k = 0..31) lands in received-word bit 31-k.
- R7: After the last data bit, select falls and exactly one more serial clock pulse follows with select low.
- R8: Done is high for exactly one cycle, 68*HALF_DIV cycles after the edge that took the start, and busy is low in that cycle.
- R9: A start strobe while busy is ignored: the frame's data, received word and length stay those of the frame in flight.
- R10: Whenever no frame is in progress, the serial clock is low and MOSI is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle frame request |
| tx_word_i | input | 32 | Word to send, captured at start |
| busy_o | output | 1 | High from the cycle after start until done |
| done_o | output | 1 | One-cycle pulse when the received word is valid |
| rx_word_o | output | 32 | Word assembled from MISO |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_o | output | 1 | Active-high select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds one instance with HALF_DIV = 3. With three clocks per phase, the phase length, the MOSI hold across the high phase and the exact done cycle each become distinct, measurable numbers. A second instance uses HALF_DIV = 1, the smallest legal divider. Its phase counter wraps on every cycle and the frame lasts the minimum 68 cycles. That instance runs with MISO looped back to MOSI, which shows that sampling at the end of a one-cycle high phase still catches the bit just sent.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_LEAD  = 2'd1,
    FS_DATA  = 2'd2,
    FS_TRAIL = 2'd3
  } frame_state_t;

  // Serial clock phases in one frame: lead pulse, data bits, trailing pulse.
  function automatic int frame_phases(input int nbits);
    return 2 + 2 * nbits + 2;
  endfunction

  // System clocks from the start edge to the done edge.
  function automatic int frame_cycles(input int nbits, input int half_div);
    return frame_phases(nbits) * half_div;
  endfunction

endpackage

// File: rtl/spm_phase_timer.sv
module spm_phase_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign phase_end = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (phase_end) cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/spm_shifter.sv
module spm_shifter #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] load_word,
  input  logic             shift,
  input  logic             sample,
  input  logic             miso,
  output logic             tx_msb,
  output logic [NBITS-1:0] rx_word
);
  logic [NBITS-1:0] tx_q;
  logic [NBITS-1:0] rx_q;

  assign tx_msb  = tx_q[NBITS-1];
  assign rx_word = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     tx_q <= '0;
    else if (load)  tx_q <= load_word;
    else if (shift) tx_q <= {tx_q[NBITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rx_q <= '0;
    else if (sample) rx_q <= {rx_q[NBITS-2:0], miso};
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(tx_q));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(rx_q));

endmodule

// File: rtl/spm_frame_ctl.sv
module spm_frame_ctl
  import spi_frame_pkg::*;
#(
  parameter int NBITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic phase_end,
  input  logic tx_msb,
  output logic load,
  output logic shift,
  output logic sample,
  output logic run,
  output logic cs_o,
  output logic sclk_o,
  output logic mosi_o,
  output logic busy_o,
  output logic done_o
);
  localparam int BW = (NBITS < 2) ? 1 : $clog2(NBITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  frame_state_t  state_q;
  logic          hi_q;
  logic          cs_q;
  logic          done_q;
  logic [BW-1:0] bidx_q;

  // Named events for the checks and the datapath.
  logic rise_evt;
  logic fall_evt;
  logic in_data;
  logic last_bit;

  assign rise_evt = phase_end && !hi_q;
  assign fall_evt = phase_end && hi_q;
  assign in_data  = (state_q == FS_DATA);
  assign last_bit = (bidx_q == LAST_BIT);

  assign load   = (state_q == FS_IDLE) && start;
  assign shift  = in_data && fall_evt;
  assign sample = in_data && fall_evt;
  assign run    = (state_q != FS_IDLE);

  assign busy_o = run;
  assign done_o = done_q;
  assign cs_o   = cs_q;
  assign sclk_o = hi_q;
  assign mosi_o = in_data && tx_msb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      hi_q    <= 1'b0;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
      bidx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rise_evt) hi_q <= 1'b1;
      if (fall_evt) hi_q <= 1'b0;
      case (state_q)
        FS_IDLE: begin
          if (start) begin
            state_q <= FS_LEAD;
            cs_q    <= 1'b1;
          end
        end
        FS_LEAD: begin
          if (fall_evt) begin
            state_q <= FS_DATA;
            bidx_q  <= '0;
          end
        end
        FS_DATA: begin
          if (fall_evt) begin
            if (last_bit) begin
              state_q <= FS_TRAIL;
              cs_q    <= 1'b0;
            end else begin
              bidx_q <= bidx_q + BW'(1);
            end
          end
        end
        FS_TRAIL: begin
          if (fall_evt) begin
            state_q <= FS_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // R2
  cs_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cs_o && busy_o));

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !mosi_o));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> (!sclk_o || $stable(mosi_o)));

  // R7
  trail_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_TRAIL) |-> !cs_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  parameter int HALF_DIV   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [WORD_BYTES*BYTE_W-1:0] tx_word_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [WORD_BYTES*BYTE_W-1:0] rx_word_o,
  output logic                         sclk_o,
  output logic                         cs_o,
  output logic                         mosi_o,
  input  logic                         miso_i
);
  localparam int NBITS     = WORD_BYTES * BYTE_W;
  localparam int FRAME_CYC = frame_cycles(NBITS, HALF_DIV);

  logic phase_end;
  logic run;
  logic load;
  logic shift;
  logic sample;
  logic tx_msb;

  spm_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .phase_end (phase_end)
  );

  spm_shifter #(.NBITS(NBITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (tx_word_i),
    .shift     (shift),
    .sample    (sample),
    .miso      (miso_i),
    .tx_msb    (tx_msb),
    .rx_word   (rx_word_o)
  );

  spm_frame_ctl #(.NBITS(NBITS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .phase_end (phase_end),
    .tx_msb    (tx_msb),
    .load      (load),
    .shift     (shift),
    .sample    (sample),
    .run       (run),
    .cs_o      (cs_o),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  // Frame length observer for the checks below.
  int unsigned len_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      len_q <= 0;
    else if (load)   len_q <= 0;
    else if (busy_o) len_q <= len_q + 1;
  end

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_q == FRAME_CYC));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (len_q == $past(len_q) + 1));

endmodule

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
  localparam int H  = 3;
  localparam int NB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // main instance
  logic        start = 1'b0;
  logic [31:0] tx = '0;
  logic        busy, done, sclk, cs, mosi;
  logic        miso = 1'b0;
  logic [31:0] rx;

  spi_frame_master #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tx_word_i(tx),
    .busy_o(busy), .done_o(done), .rx_word_o(rx),
    .sclk_o(sclk), .cs_o(cs), .mosi_o(mosi), .miso_i(miso));

  // minimum-divider instance, MISO looped back to MOSI
  logic        start2 = 1'b0;
  logic [31:0] tx2 = '0;
  logic        busy2, done2, sclk2, cs2, mosi2;
  logic [31:0] rx2;

  spi_frame_master #(.HALF_DIV(1)) uut_min (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .tx_word_i(tx2),
    .busy_o(busy2), .done_o(done2), .rx_word_o(rx2),
    .sclk_o(sclk2), .cs_o(cs2), .mosi_o(mosi2), .miso_i(mosi2));

  // peripheral model for the main instance
  int          rise_cs, rise_nocs, fall_cs, t_rise, hi_len;
  logic [31:0] mon_tx, rx_pat;

  always @(posedge sclk) begin
    t_rise = cyc;
    if (cs) begin
      rise_cs++;
      if (rise_cs > 1) mon_tx = {mon_tx[30:0], mosi};
    end else begin
      rise_nocs++;
    end
  end

  always @(negedge sclk) begin
    hi_len = cyc - t_rise;
    if (cs) begin
      fall_cs++;
      if (fall_cs <= NB) miso = rx_pat[NB - fall_cs];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cs && !sclk && !mosi, "R1 lines after reset", {cs, sclk, mosi}, 0);
    check(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    check(rx == 0, "R1 rx after reset", rx, 0);
  endtask

  // Runs one frame; a second start with other data is strobed mid-frame if spoil.
  task automatic t_frame(input logic [31:0] word, input logic [31:0] pat, input bit spoil);
    int n;
    rise_cs = 0; rise_nocs = 0; fall_cs = 0; mon_tx = '0;
    rx_pat = pat; miso = 1'b0;
    @(negedge clk);
    tx = word; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(cs && busy, "R2 cs/busy after start", {cs, busy}, 2'b11);
    while (!done && n < 5000) begin
      if (spoil && n == 100) begin tx = ~word; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == 68 * H + 1, spoil ? "R9 frame length with spoiling start" : "R8 done cycle",
          n, 68 * H + 1);
    check(!busy && !cs, "R8 busy low at done", {busy, cs}, 0);
    check(rise_cs == 33, "R3 rises with cs high", rise_cs, 33);
    check(mon_tx == word, spoil ? "R9 data unchanged by spoil" : "R4 data order", mon_tx, word);
    check(rx == pat, spoil ? "R9 rx unchanged by spoil" : "R6 rx assembly", rx, pat);
    check(rise_nocs == 1, "R7 trailing pulse count", rise_nocs, 1);
    check(hi_len == H, "R5 high phase length", hi_len, H);
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    check(!sclk && !mosi, "R10 idle lines", {sclk, mosi}, 0);
  endtask

  task automatic t_min_div(input logic [31:0] word);
    int n;
    @(negedge clk);
    tx2 = word; start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    n = 1;
    while (!done2 && n < 5000) begin @(negedge clk); n++; end
    check(n == 69, "R5 frame length at HALF_DIV=1", n, 69);
    check(rx2 == word, "R6 loopback at HALF_DIV=1", rx2, word);
    check(!busy2 && !sclk2 && !mosi2, "R10 idle at HALF_DIV=1", {busy2, sclk2, mosi2}, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(32'h02FE_AA0F, 32'hA5C3_0F81, 1'b0);
    t_frame(32'hFFA0_1110, 32'h0000_0001, 1'b0);
    t_frame(32'h8000_0001, 32'hFFFF_FFFF, 1'b0);
    t_frame(32'h1234_5678, 32'h8765_4321, 1'b1);
    t_min_div(32'hC3A5_0FF0);
    t_min_div(32'h0000_0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule